// File: doc/BRIEF.md
# Scratchpad Transfer CRC-16 Unit

This unit computes the 16-bit CRC that protects scratchpad write and read transfers on a serial memory link. It sees the link one byte at a time. A clear strobe starts each transaction. After that the unit absorbs the command byte, the two target address bytes and every data byte, in that order and exactly as they cross the link. The running value goes through the standard CRC-16 polynomial x^16 + x^15 + x^2 + 1. Each byte is taken least significant bit first, using the reflected feedback constant 0xA001.

The unit always presents its result inverted, so that the transmitter can send it straight out, low byte first. When the unit receives a CRC, it checks the two incoming inverted bytes by shifting them through the same register. A correct pair leaves a fixed residue. On a mismatch the controlling logic knows it must re-read the affected data and not continue. Command decoding and storage lie outside this block.

Top module: `crc16_scratch_unit`

## Requirements
- R1: While reset is asserted and once it is released, the CRC register holds 0x0000. The outputs show `crc_out_o` = 0xFFFF, `chk_done_o` = 0 and `crc_match_o` = 0.
- R2: A cycle with `clr_i` = 1 clears the CRC register to 0x0000, so `crc_out_o` = 0xFFFF from the next cycle. It also clears the count of received check bytes. `clr_i` wins over a `byte_valid_i` in the same cycle, and that byte is not absorbed.
- R3: A cycle with `byte_valid_i` = 1 and `byte_chk_i` = 0 absorbs `byte_in_i` into the register. The bits go in LSB first with reflected constant 0xA001. The new value shows on the outputs from the next cycle. Absorbing ASCII "123456789" after a clear gives `crc_out_o` = 0x44C2.
- R4: A cycle with `byte_valid_i` = 0 leaves the register and all outputs unchanged, whatever `byte_in_i` carries.
- R5: `crc_out_o` is the bitwise inverse of the register. Bits [7:0] are the byte transmitted first and bits [15:8] the byte transmitted second.
- R6: Bytes with `byte_chk_i` = 1 are received CRC bytes, low byte first. After the second one, `chk_done_o` = 1. At that point `crc_match_o` = 1 exactly when the two bytes equal bits [7:0] and then bits [15:8] of `crc_out_o` as it stood before the first of them. A correct pair leaves the register at 0xB001.
- R7: Once `chk_done_o` = 1, every further byte is ignored and `crc_out_o`, `chk_done_o` and `crc_match_o` hold their values until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Clear strobe that starts a transaction |
| byte_valid_i | input | 1 | `byte_in_i` carries a byte this cycle |
| byte_chk_i | input | 1 | 0: message byte (command, address, data); 1: received CRC byte |
| byte_in_i | input | 8 | Byte from the link |
| crc_out_o | output | 16 | Inverted CRC; [7:0] is sent first |
| chk_done_o | output | 1 | Both received CRC bytes have been taken |
| crc_match_o | output | 1 | Received CRC matched (valid while `chk_done_o` = 1) |

## Verification
The bench drives a clear and a byte in the same cycle. A design that let the byte win would show a non-FFFF value afterwards, or would start the next CRC from a corrupted base. It corrupts only the low check byte in some transfers and only the high byte in others. A design that compared just one byte, or swapped the byte order, would flag a match that is wrong. It sends extra bytes after the check is complete and idles the byte strobe while `byte_in_i` toggles. A design that kept absorbing would drift its output and lose the match. The known "123456789" value catches a wrong bit order or feedback constant.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'hA001;
  localparam logic [CRC_W-1:0] CRC_INIT  = 16'h0000;
  localparam logic [CRC_W-1:0] RESIDUE   = 16'hB001;
  localparam int CHK_BYTES = CRC_W / BYTE_W;

  typedef enum logic {
    BYTE_MSG = 1'b0,
    BYTE_CHK = 1'b1
  } byte_kind_e;
endpackage

// File: rtl/crc16_rst_sync.sv
module crc16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int                CRC_W  = 16,
  parameter int                DATA_W = 8,
  parameter logic [CRC_W-1:0]  POLY   = 16'hA001
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  state_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = state_i;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic fb;
      assign fb           = chain[i][0] ^ data_i[i];
      assign chain[i+1]   = (chain[i] >> 1) ^ (fb ? POLY : '0);
    end
  endgenerate

  assign state_o = chain[DATA_W];
endmodule

// File: rtl/crc16_chk_track.sv
module crc16_chk_track #(
  parameter int NBYTES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic take_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (take_i && (cnt_q != CNT_FULL));
    cnt_d  = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == CNT_FULL);

  // R2
  clr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/crc16_scratch_unit.sv
module crc16_scratch_unit
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_valid_i,
  input  logic              byte_chk_i,
  input  logic [BYTE_W-1:0] byte_in_i,
  output logic [CRC_W-1:0]  crc_out_o,
  output logic              chk_done_o,
  output logic              crc_match_o
);
  logic             rst_n_s;
  logic [CRC_W-1:0] crc_q, crc_d, crc_step;
  logic             crc_en, accept, take_chk, done;
  byte_kind_e       kind;

  crc16_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  crc16_byte_step #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(POLY_REFL)) u_step (
    .state_i (crc_q),
    .data_i  (byte_in_i),
    .state_o (crc_step)
  );

  crc16_chk_track #(.NBYTES(CHK_BYTES)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (clr_i),
    .take_i (take_chk),
    .done_o (done)
  );

  assign kind     = byte_kind_e'(byte_chk_i);
  assign accept   = byte_valid_i && !done && !clr_i;
  assign take_chk = accept && (kind == BYTE_CHK);

  always_comb begin
    crc_en = clr_i || accept;
    crc_d  = crc_q;
    if (clr_i)       crc_d = CRC_INIT;
    else if (accept) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    crc_q <= CRC_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_out_o   = ~crc_q;
  assign chk_done_o  = done;
  assign crc_match_o = done && (crc_q == RESIDUE);

  // R2
  clr_value_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr_i |=> (crc_out_o == ~CRC_INIT) && !chk_done_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!clr_i && !byte_valid_i) |=> $stable(crc_out_o) && $stable(crc_match_o));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (chk_done_o && !clr_i) |=> chk_done_o && $stable(crc_out_o));

  // R6
  match_gated_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    crc_match_o |-> chk_done_o);
endmodule

// File: tb/tb_crc16_scratch_unit.sv
`timescale 1ns/1ps
module tb_crc16_scratch_unit;
  logic        clk = 1'b0;
  logic        rst_n, clr, vld, chk;
  logic [7:0]  din;
  logic [15:0] crc_out;
  logic        done, match;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  crc16_scratch_unit dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .byte_valid_i(vld),
    .byte_chk_i(chk), .byte_in_i(din), .crc_out_o(crc_out),
    .chk_done_o(done), .crc_match_o(match)
  );

  // Vectors: {cmd, ta1, ta2, data}; corrupt code 0 none, 1 low check byte, 2 high check byte
  localparam logic [31:0] MSGS [8] = '{
    32'h0F_00_00_AA, 32'h0F_20_00_55, 32'hF0_00_00_00, 32'hAA_1F_00_FF,
    32'h0F_08_00_C3, 32'hF0_7F_00_01, 32'h0F_10_00_80, 32'hAA_00_00_3C };
  localparam logic [1:0] CORRUPT [8] = '{0, 1, 0, 2, 0, 1, 2, 0};

  function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic v, input logic k, input logic [7:0] b);
    @(negedge clk);
    clr = c; vld = v; chk = k; din = b;
    @(negedge clk);
    clr = 0; vld = 0; chk = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] m, snap;
    logic [7:0]  lo, hi;
    rst_n = 0; clr = 0; vld = 0; chk = 0; din = 0;
    repeat (3) @(negedge clk);
    // R1 reset state while asserted
    check("R1 crc_out in reset", crc_out, 16'hFFFF);
    check("R1 done/match in reset", {14'd0, done, match}, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 crc_out after release", crc_out, 16'hFFFF);

    // Table walk: R3 R5 R6
    foreach (MSGS[i]) begin
      put(1, 0, 0, 8'h00);
      m = 16'h0000;
      for (int j = 3; j >= 0; j--) begin
        put(0, 1, 0, MSGS[i][j*8 +: 8]);
        m = model(m, MSGS[i][j*8 +: 8]);
      end
      check("R3 R5 crc_out vector", crc_out, ~m);
      lo = ~m[7:0]; hi = ~m[15:8];
      if (CORRUPT[i] == 2'd1) lo = lo ^ 8'h10;
      if (CORRUPT[i] == 2'd2) hi = hi ^ 8'h01;
      put(0, 1, 1, lo);
      check("R6 done after one check byte", {15'd0, done}, 16'd0);
      put(0, 1, 1, hi);
      check("R6 done", {15'd0, done}, 16'd1);
      check("R6 match", {15'd0, match}, {15'd0, CORRUPT[i] == 2'd0});
    end

    // R3 known value
    put(1, 0, 0, 8'h00);
    for (int j = 0; j < 9; j++) put(0, 1, 0, 8'h31 + 8'(j));
    check("R3 known 123456789", crc_out, 16'h44C2);

    // R4 idle with toggling data
    snap = crc_out;
    for (int j = 0; j < 5; j++) put(0, 0, j[0], 8'hA5 ^ 8'(j));
    check("R4 idle hold", crc_out, snap);

    // R2 clear priority over a byte in the same cycle
    put(1, 1, 0, 8'h55);
    check("R2 clear wins", crc_out, 16'hFFFF);
    put(0, 1, 0, 8'h12);
    check("R2 byte not absorbed", crc_out, ~model(16'h0000, 8'h12));

    // R7 bytes after completion ignored
    m = model(16'h0000, 8'h12);
    put(0, 1, 1, ~m[7:0]);
    put(0, 1, 1, ~m[15:8]);
    check("R7 match before extras", {15'd0, match}, 16'd1);
    snap = crc_out;
    put(0, 1, 0, 8'h77);
    put(0, 1, 1, 8'h99);
    check("R7 crc_out held", crc_out, snap);
    check("R7 match held", {14'd0, done, match}, 16'd3);
    check("R6 residue", crc_out, ~16'hB001);

    // R2 clear resets check state
    put(1, 0, 0, 8'h00);
    check("R2 clear resets done", {14'd0, done, match}, 16'd0);

    finish_run();
  end
endmodule